// File: doc/BRIEF.md
# Frequent Value Compressed Cache Datapath

This block is the data side of a small direct-mapped cache in which every 32-bit word of a line is stored in one of two forms. A word that equals an entry of a 256-entry table of frequently seen values is kept as that entry's 8-bit index. Any other word is kept in full. The storage is split into two arrays. The low array holds the bottom 8 bits of every word slot, which is either the index or the real low byte. The high array holds the upper 24 bits. A flag for each word, stored next to the line's tag, tells the two forms apart.

A read always touches only the low array first. If the flag shows a compressed word, the fetched byte selects a table entry, and that entry is the answer one cycle after the request. If the word is stored in full, the block raises busy for one cycle while it fetches the upper 24 bits from the high array. It then answers with the joined word two cycles after the request.

Fills write a whole line of four words. Each word is matched against the table as it is written. The table has its own write port and is loaded before the cache is used.

Top module: `fvc_cache`

## Requirements
- R1: After reset, busy and rsp_valid are low, and every line is invalid, so a read of any address is answered as a miss.
- R2: A write on the table port replaces the table entry at tbl_addr with tbl_wdata from the next cycle on.
- R3: On a fill, a word equal to some table entry is stored compressed as that entry's index. When several entries hold the same value, the lowest index is stored.
- R4: On a fill, a word equal to no table entry is stored uncompressed with all 32 bits.
- R5: A read hitting a compressed word drives rsp_valid and rsp_comp high in the cycle after the request is accepted, with rsp_data equal to the table entry its index selects.
- R6: A read hitting an uncompressed word drives busy high, with rsp_valid low, in the cycle after acceptance. In the cycle after that, it drives rsp_valid high, rsp_comp low and rsp_data equal to the full stored word.
- R7: A read whose tag differs from the line's tag, or whose line is invalid, drives rsp_valid and rsp_miss high with rsp_data zero in the cycle after acceptance.
- R8: busy is never high for two cycles in a row, and a request presented while busy is high is ignored and produces no response.
- R9: Compressed and uncompressed words in one line are each read back in their own form, as their own flags select.
- R10: A compressed word holds an index and not a value, so after its table entry is rewritten, a read returns the new entry contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_we | input | 1 | Frequent value table write enable |
| tbl_addr | input | 8 | Table entry to write |
| tbl_wdata | input | 32 | Value for the table entry |
| fill_we | input | 1 | Line fill enable |
| fill_tag | input | 8 | Tag of the filled line |
| fill_index | input | 4 | Line index of the fill |
| fill_data | input | 128 | Four words, word 0 in the low bits |
| rd_req | input | 1 | Read request, ignored while busy |
| rd_tag | input | 8 | Tag of the read address |
| rd_index | input | 4 | Line index of the read |
| rd_off | input | 2 | Word offset in the line |
| busy | output | 1 | High during the upper-bits fetch cycle |
| rsp_valid | output | 1 | Response strobe |
| rsp_miss | output | 1 | Response is a miss |
| rsp_comp | output | 1 | Response came from a compressed word |
| rsp_data | output | 32 | Read data, zero on a miss |

## Verification
The assertions check on every cycle that busy lasts a single cycle and is always followed by a hit response from an uncompressed word. They also check that a miss carries zero data, that a compressed response follows an accepted request, and that a table write takes effect. Only the bench's scenarios can show that the values returned are correct. This covers the choice of the lowest duplicate index, the low byte of an uncompressed word that happens to look like an index, the dropping of a request made during busy, and the use of rewritten table contents by words filled earlier.

// File: rtl/fvc_pkg.sv
`timescale 1ns/1ps
package fvc_pkg;
    localparam int DEF_WORD_W = 32;
    localparam int DEF_LO_W   = 8;
    localparam int DEF_WPL    = 4;
    localparam int DEF_LINES  = 16;
    localparam int DEF_TAG_W  = 8;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_MISS = 2'd1,
        RD_COMP = 2'd2,
        RD_FULL = 2'd3
    } rd_kind_e;
endpackage

// File: rtl/fvc_value_table.sv
`timescale 1ns/1ps
module fvc_value_table #(
    parameter int WORD_W = 32,
    parameter int IDX_W  = 8,
    parameter int WPL    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_addr,
    input  logic [WORD_W-1:0]     wr_data,
    input  logic [IDX_W-1:0]      look_idx,
    output logic [WORD_W-1:0]     look_val,
    input  logic [WPL*WORD_W-1:0] cmp_words,
    output logic [WPL-1:0]        cmp_hit,
    output logic [WPL*IDX_W-1:0]  cmp_idx
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [WORD_W-1:0] tbl_d [ENTRIES];
    logic [WORD_W-1:0] tbl_q [ENTRIES];

    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            tbl_d[e] = tbl_q[e];
        end
        if (wr_en) begin
            tbl_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                tbl_q[e] <= '0;
            end
        end else begin
            for (int e = 0; e < ENTRIES; e++) begin
                tbl_q[e] <= tbl_d[e];
            end
        end
    end

    assign look_val = tbl_q[look_idx];

    // One match unit per word; searched from the top so the lowest index wins.
    for (genvar w = 0; w < WPL; w++) begin : g_cmp
        logic [WORD_W-1:0] word_w;
        logic              hit_w;
        logic [IDX_W-1:0]  idx_w;
        assign word_w = cmp_words[w*WORD_W +: WORD_W];
        always_comb begin
            hit_w = 1'b0;
            idx_w = '0;
            for (int e = ENTRIES - 1; e >= 0; e--) begin
                if (tbl_q[e] == word_w) begin
                    hit_w = 1'b1;
                    idx_w = IDX_W'(e);
                end
            end
        end
        assign cmp_hit[w] = hit_w;
        assign cmp_idx[w*IDX_W +: IDX_W] = idx_w;
    end

    p_tbl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> tbl_q[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/fvc_line_store.sv
`timescale 1ns/1ps
module fvc_line_store #(
    parameter int WORD_W = 32,
    parameter int LO_W   = 8,
    parameter int WPL    = 4,
    parameter int LINES  = 16,
    parameter int TAG_W  = 8,
    localparam int HI_W  = WORD_W - LO_W,
    localparam int IX_W  = $clog2(LINES),
    localparam int OFF_W = $clog2(WPL)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fill_en,
    input  logic [IX_W-1:0]      fill_idx,
    input  logic [TAG_W-1:0]     fill_tag,
    input  logic [WPL*LO_W-1:0]  fill_lo,
    input  logic [WPL*HI_W-1:0]  fill_hi,
    input  logic [WPL-1:0]       fill_flags,
    input  logic [IX_W-1:0]      rd_idx,
    input  logic [TAG_W-1:0]     rd_tag,
    input  logic [OFF_W-1:0]     rd_off,
    output logic                 rd_hit,
    output logic                 rd_flag,
    output logic [LO_W-1:0]      rd_lo,
    input  logic [IX_W-1:0]      hi_idx,
    input  logic [OFF_W-1:0]     hi_off,
    output logic [HI_W-1:0]      hi_data
);
    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [WPL-1:0]   flags;
    } line_meta_t;

    line_meta_t          meta_d [LINES];
    line_meta_t          meta_q [LINES];
    logic [WPL*LO_W-1:0] lo_d   [LINES];
    logic [WPL*LO_W-1:0] lo_q   [LINES];
    logic [WPL*HI_W-1:0] hi_d   [LINES];
    logic [WPL*HI_W-1:0] hi_q   [LINES];

    always_comb begin
        for (int l = 0; l < LINES; l++) begin
            meta_d[l] = meta_q[l];
            lo_d[l]   = lo_q[l];
            hi_d[l]   = hi_q[l];
        end
        if (fill_en) begin
            meta_d[fill_idx].valid = 1'b1;
            meta_d[fill_idx].tag   = fill_tag;
            meta_d[fill_idx].flags = fill_flags;
            lo_d[fill_idx]         = fill_lo;
            hi_d[fill_idx]         = fill_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int l = 0; l < LINES; l++) begin
                meta_q[l] <= '0;
            end
        end else begin
            for (int l = 0; l < LINES; l++) begin
                meta_q[l] <= meta_d[l];
            end
        end
    end

    // Data arrays carry no reset: the valid bit guards them.
    always_ff @(posedge clk) begin
        for (int l = 0; l < LINES; l++) begin
            lo_q[l] <= lo_d[l];
            hi_q[l] <= hi_d[l];
        end
    end

    // First access: tag, flag and low array only.
    assign rd_hit  = meta_q[rd_idx].valid && (meta_q[rd_idx].tag == rd_tag);
    assign rd_flag = meta_q[rd_idx].flags[rd_off];
    assign rd_lo   = lo_q[rd_idx][rd_off*LO_W +: LO_W];

    // Second access: high array only.
    assign hi_data = hi_q[hi_idx][hi_off*HI_W +: HI_W];
endmodule

// File: rtl/fvc_read_seq.sv
`timescale 1ns/1ps
module fvc_read_seq
    import fvc_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LO_W   = 8,
    parameter int LINES  = 16,
    parameter int WPL    = 4,
    localparam int HI_W  = WORD_W - LO_W,
    localparam int IX_W  = $clog2(LINES),
    localparam int OFF_W = $clog2(WPL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [IX_W-1:0]   rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    input  logic              st_hit,
    input  logic              st_flag,
    input  logic [LO_W-1:0]   st_lo,
    output logic [IX_W-1:0]   hi_idx,
    output logic [OFF_W-1:0]  hi_off,
    input  logic [HI_W-1:0]   hi_data,
    output logic [LO_W-1:0]   look_idx,
    input  logic [WORD_W-1:0] look_val,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_miss,
    output logic              rsp_comp,
    output logic [WORD_W-1:0] rsp_data
);
    typedef struct packed {
        rd_kind_e         kind1;
        logic [LO_W-1:0]  lo1;
        logic [IX_W-1:0]  idx1;
        logic [OFF_W-1:0] off1;
        logic             full2;
        logic [LO_W-1:0]  lo2;
        logic [HI_W-1:0]  hi2;
    } seq_t;

    seq_t s_d, s_q;
    logic accept;

    assign busy   = (s_q.kind1 == RD_FULL);
    assign accept = rd_req && !busy;

    always_comb begin
        s_d = s_q;
        if (accept) begin
            if (!st_hit) begin
                s_d.kind1 = RD_MISS;
            end else if (st_flag) begin
                s_d.kind1 = RD_COMP;
            end else begin
                s_d.kind1 = RD_FULL;
            end
            s_d.lo1  = st_lo;
            s_d.idx1 = rd_idx;
            s_d.off1 = rd_off;
        end else begin
            s_d.kind1 = RD_NONE;
        end
        s_d.full2 = busy;
        if (busy) begin
            s_d.lo2 = s_q.lo1;
            s_d.hi2 = hi_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hi_idx   = s_q.idx1;
    assign hi_off   = s_q.off1;
    assign look_idx = s_q.lo1;

    always_comb begin
        rsp_valid = 1'b0;
        rsp_miss  = 1'b0;
        rsp_comp  = 1'b0;
        rsp_data  = '0;
        if (s_q.full2) begin
            rsp_valid = 1'b1;
            rsp_data  = {s_q.hi2, s_q.lo2};
        end else if (s_q.kind1 == RD_COMP) begin
            rsp_valid = 1'b1;
            rsp_comp  = 1'b1;
            rsp_data  = look_val;
        end else if (s_q.kind1 == RD_MISS) begin
            rsp_valid = 1'b1;
            rsp_miss  = 1'b1;
        end
    end

    p_busy_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    p_busy_then_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> rsp_valid && !rsp_miss && !rsp_comp);
    p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> rsp_valid && (rsp_data == '0) && !rsp_comp);
    p_comp_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_comp |-> $past(rd_req && !busy));
endmodule

// File: rtl/fvc_cache.sv
`timescale 1ns/1ps
module fvc_cache #(
    parameter int WORD_W = fvc_pkg::DEF_WORD_W,
    parameter int LO_W   = fvc_pkg::DEF_LO_W,
    parameter int WPL    = fvc_pkg::DEF_WPL,
    parameter int LINES  = fvc_pkg::DEF_LINES,
    parameter int TAG_W  = fvc_pkg::DEF_TAG_W,
    localparam int HI_W  = WORD_W - LO_W,
    localparam int IX_W  = $clog2(LINES),
    localparam int OFF_W = $clog2(WPL)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tbl_we,
    input  logic [LO_W-1:0]       tbl_addr,
    input  logic [WORD_W-1:0]     tbl_wdata,
    input  logic                  fill_we,
    input  logic [TAG_W-1:0]      fill_tag,
    input  logic [IX_W-1:0]       fill_index,
    input  logic [WPL*WORD_W-1:0] fill_data,
    input  logic                  rd_req,
    input  logic [TAG_W-1:0]      rd_tag,
    input  logic [IX_W-1:0]       rd_index,
    input  logic [OFF_W-1:0]      rd_off,
    output logic                  busy,
    output logic                  rsp_valid,
    output logic                  rsp_miss,
    output logic                  rsp_comp,
    output logic [WORD_W-1:0]     rsp_data
);
    logic [WPL-1:0]       cmp_hit;
    logic [WPL*LO_W-1:0]  cmp_idx;
    logic [WPL*LO_W-1:0]  pack_lo;
    logic [WPL*HI_W-1:0]  pack_hi;
    logic                 st_hit, st_flag;
    logic [LO_W-1:0]      st_lo;
    logic [IX_W-1:0]      hi_idx;
    logic [OFF_W-1:0]     hi_off;
    logic [HI_W-1:0]      hi_data;
    logic [LO_W-1:0]      look_idx;
    logic [WORD_W-1:0]    look_val;

    fvc_value_table #(.WORD_W(WORD_W), .IDX_W(LO_W), .WPL(WPL)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (tbl_we),
        .wr_addr   (tbl_addr),
        .wr_data   (tbl_wdata),
        .look_idx  (look_idx),
        .look_val  (look_val),
        .cmp_words (fill_data),
        .cmp_hit   (cmp_hit),
        .cmp_idx   (cmp_idx)
    );

    // Per-word packing: index into the low slot, or the word split in two.
    for (genvar w = 0; w < WPL; w++) begin : g_pack
        logic [WORD_W-1:0] word_w;
        assign word_w = fill_data[w*WORD_W +: WORD_W];
        assign pack_lo[w*LO_W +: LO_W] = cmp_hit[w] ? cmp_idx[w*LO_W +: LO_W]
                                                     : word_w[LO_W-1:0];
        assign pack_hi[w*HI_W +: HI_W] = cmp_hit[w] ? '0 : word_w[WORD_W-1:LO_W];
    end

    fvc_line_store #(.WORD_W(WORD_W), .LO_W(LO_W), .WPL(WPL),
                     .LINES(LINES), .TAG_W(TAG_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_en    (fill_we),
        .fill_idx   (fill_index),
        .fill_tag   (fill_tag),
        .fill_lo    (pack_lo),
        .fill_hi    (pack_hi),
        .fill_flags (cmp_hit),
        .rd_idx     (rd_index),
        .rd_tag     (rd_tag),
        .rd_off     (rd_off),
        .rd_hit     (st_hit),
        .rd_flag    (st_flag),
        .rd_lo      (st_lo),
        .hi_idx     (hi_idx),
        .hi_off     (hi_off),
        .hi_data    (hi_data)
    );

    fvc_read_seq #(.WORD_W(WORD_W), .LO_W(LO_W), .LINES(LINES), .WPL(WPL)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .rd_idx    (rd_index),
        .rd_off    (rd_off),
        .st_hit    (st_hit),
        .st_flag   (st_flag),
        .st_lo     (st_lo),
        .hi_idx    (hi_idx),
        .hi_off    (hi_off),
        .hi_data   (hi_data),
        .look_idx  (look_idx),
        .look_val  (look_val),
        .busy      (busy),
        .rsp_valid (rsp_valid),
        .rsp_miss  (rsp_miss),
        .rsp_comp  (rsp_comp),
        .rsp_data  (rsp_data)
    );

    p_resp_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_miss, rsp_comp}) <= 1);
endmodule

// File: tb/sim_fvc_cache.sv
`timescale 1ns/1ps
module sim_fvc_cache;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tbl_we = 1'b0;
    logic [7:0]   tbl_addr = '0;
    logic [31:0]  tbl_wdata = '0;
    logic         fill_we = 1'b0;
    logic [7:0]   fill_tag = '0;
    logic [3:0]   fill_index = '0;
    logic [127:0] fill_data = '0;
    logic         rd_req = 1'b0;
    logic [7:0]   rd_tag = '0;
    logic [3:0]   rd_index = '0;
    logic [1:0]   rd_off = '0;
    logic         busy, rsp_valid, rsp_miss, rsp_comp;
    logic [31:0]  rsp_data;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fvc_cache u0 (.*);

    // {tag, index, off, miss, comp, data}
    localparam logic [47:0] VEC [14] = '{
        {8'h11, 4'd2,  2'd0, 1'b0, 1'b1, 32'h5A000500},
        {8'h11, 4'd2,  2'd1, 1'b0, 1'b0, 32'hDEADBEEF},
        {8'h11, 4'd2,  2'd2, 1'b0, 1'b1, 32'h5A00FF00},
        {8'h11, 4'd2,  2'd3, 1'b0, 1'b0, 32'h00000042},
        {8'h3C, 4'd7,  2'd0, 1'b0, 1'b0, 32'h01234567},
        {8'h3C, 4'd7,  2'd1, 1'b0, 1'b0, 32'h89ABCDEF},
        {8'h3C, 4'd7,  2'd2, 1'b0, 1'b0, 32'hCAFEF00D},
        {8'h3C, 4'd7,  2'd3, 1'b0, 1'b0, 32'h0BADC0DE},
        {8'hFF, 4'd15, 2'd0, 1'b0, 1'b1, 32'h5A000000},
        {8'hFF, 4'd15, 2'd1, 1'b0, 1'b1, 32'h5A000100},
        {8'hFF, 4'd15, 2'd2, 1'b0, 1'b1, 32'h5A008000},
        {8'hFF, 4'd15, 2'd3, 1'b0, 1'b1, 32'h5A00FE00},
        {8'h12, 4'd2,  2'd0, 1'b1, 1'b0, 32'h00000000},
        {8'h00, 4'd9,  2'd1, 1'b1, 1'b0, 32'h00000000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tbl_write(input logic [7:0] a, input logic [31:0] v);
        tbl_we = 1'b1; tbl_addr = a; tbl_wdata = v;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic fill(input logic [7:0] t, input logic [3:0] ix, input logic [127:0] d);
        fill_we = 1'b1; fill_tag = t; fill_index = ix; fill_data = d;
        @(negedge clk);
        fill_we = 1'b0;
    endtask

    // Request driven at a falling edge, accepted at the next rising edge.
    task automatic do_read(input string req, input logic [7:0] t, input logic [3:0] ix,
                           input logic [1:0] off, input logic miss, input logic comp,
                           input logic [31:0] data);
        rd_req = 1'b1; rd_tag = t; rd_index = ix; rd_off = off;
        @(negedge clk);
        rd_req = 1'b0;
        if (miss || comp) begin
            chk(req, {28'd0, busy, rsp_valid, rsp_miss, rsp_comp}, {28'd0, 1'b0, 1'b1, miss, comp});
            chk(req, rsp_data, data);
        end else begin
            chk(req, {30'd0, busy, rsp_valid}, {30'd0, 2'b10});
            @(negedge clk);
            chk(req, {28'd0, busy, rsp_valid, rsp_miss, rsp_comp}, 32'b0100);
            chk(req, rsp_data, data);
        end
        @(negedge clk);
        chk(req, {31'd0, rsp_valid}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs and all lines invalid after reset
        chk("R1 idle", {30'd0, busy, rsp_valid}, 32'd0);
        do_read("R1 invalid", 8'h00, 4'd0, 2'd0, 1'b1, 1'b0, 32'd0);

        for (int i = 0; i < 256; i++) begin
            tbl_write(i[7:0], 32'h5A000000 | (i << 8));
        end
        tbl_write(8'd3, 32'h12345678);
        tbl_write(8'd200, 32'h12345678);

        fill(8'h11, 4'd2,  {32'h00000042, 32'h5A00FF00, 32'hDEADBEEF, 32'h5A000500});
        fill(8'h3C, 4'd7,  {32'h0BADC0DE, 32'hCAFEF00D, 32'h89ABCDEF, 32'h01234567});
        fill(8'hFF, 4'd15, {32'h5A00FE00, 32'h5A008000, 32'h5A000100, 32'h5A000000});
        fill(8'h20, 4'd4,  {32'h00000004, 32'h00000003, 32'hFFFFFFFF, 32'h12345678});

        // R4 R5 R6 R7 R9: vector walk
        for (int v = 0; v < 14; v++) begin
            do_read($sformatf("R5 R6 R7 R9 vector %0d", v), VEC[v][47:40], VEC[v][39:36],
                    VEC[v][35:34], VEC[v][33], VEC[v][32], VEC[v][31:0]);
        end

        // R3: duplicate value compressed; R4 raw words beside it
        do_read("R3 duplicate", 8'h20, 4'd4, 2'd0, 1'b0, 1'b1, 32'h12345678);
        do_read("R4 raw ones", 8'h20, 4'd4, 2'd1, 1'b0, 1'b0, 32'hFFFFFFFF);
        do_read("R4 raw small", 8'h20, 4'd4, 2'd2, 1'b0, 1'b0, 32'h00000003);

        // R2 R10 R3: rewrite entry 3; lowest index must have been stored
        tbl_write(8'd3, 32'h00007777);
        do_read("R10 R3 rewritten entry", 8'h20, 4'd4, 2'd0, 1'b0, 1'b1, 32'h00007777);
        tbl_write(8'd5, 32'hABCD0005);
        do_read("R2 table write", 8'h11, 4'd2, 2'd0, 1'b0, 1'b1, 32'hABCD0005);

        // R8: request during busy is dropped
        rd_req = 1'b1; rd_tag = 8'h3C; rd_index = 4'd7; rd_off = 2'd2;
        @(negedge clk);
        chk("R8 busy", {31'd0, busy}, 32'd1);
        rd_tag = 8'hFF; rd_index = 4'd15; rd_off = 2'd1;
        @(negedge clk);
        rd_req = 1'b0;
        chk("R8 full answer", {28'd0, busy, rsp_valid, rsp_miss, rsp_comp}, 32'b0100);
        chk("R8 full data", rsp_data, 32'hCAFEF00D);
        @(negedge clk);
        chk("R8 dropped", {30'd0, busy, rsp_valid}, 32'd0);
        @(negedge clk);
        chk("R8 still idle", {31'd0, rsp_valid}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule